// File: doc/BRIEF.md
# Serial Control-Register Write Port

This block is a write-only synchronous serial slave. A host lowers an active-low select line, clocks in one 24-bit frame and raises the select line again. The block loads the frame into one of two 16-bit configuration registers inside a system-clock design. The first eight bits received form an address and the next sixteen bits form the data word. Both are sent most significant bit first and captured on the rising edge of the serial clock. Select, serial clock, serial data and the vertical-sync input each pass through a two-flop synchronizer, and all edges are detected after synchronization.

The control register collects the analog front end's static settings. These are a 5-bit clamp level, a soft-reset bit, an input selector, a low-power bit, a 2-bit lead-in hold time and a 2-bit lead-in gain multiplier. The gain register carries a 10-bit amplifier gain and a timing-select bit. That bit decides whether the new gain becomes active when the select line is released or waits for the next falling edge of vertical sync. Each time the active gain value changes, the block emits a one-cycle pulse that downstream logic uses to start fast acquisition. A frame with too few or too many serial clocks is discarded.

The framing state machine has four states. ST_IDLE waits with select high and moves to ST_SHIFT on a select falling edge. ST_SHIFT counts serial-clock rising edges. After the 24th edge it moves to ST_FULL. If select rises before that, it aborts back to ST_IDLE. In ST_FULL, a select rising edge commits the frame and returns to ST_IDLE, while a further serial-clock edge moves to ST_OVER. ST_OVER returns to ST_IDLE on the select rising edge without committing anything.

Top module: `ser_cfg_port`

## Requirements
- R1: After reset, `ctrl_q` reads 16'h0009, `gain_q` reads 0, `gain_on_vsync` reads 0, and no `gain_chg` pulse occurs.
- R2: A frame of exactly 24 serial-clock rising edges, sent as address[7:0] then data[15:0] MSB first, is committed at the select release. Address 8'hA2 loads `ctrl_q` with the data word. The field positions are clamp [4:0], soft reset [5], input select [6], low power [7], lead-in hold [9:8] and lead-in multiplier [11:10].
- R3: A frame released after fewer than 24 serial-clock rising edges changes no register.
- R4: A frame with more than 24 serial-clock rising edges changes no register.
- R5: A complete frame to any address other than 8'hA2 or 8'hA4 changes no register.
- R6: A complete frame to address 8'hA4 with data bit 15 = 0 loads data[9:0] into `gain_q` at the select release and drives `gain_on_vsync` to 0.
- R7: A complete frame to address 8'hA4 with data bit 15 = 1 leaves `gain_q` unchanged and drives `gain_on_vsync` to 1. The staged value data[9:0] becomes `gain_q` at the next synchronized falling edge of `vsync`.
- R8: `gain_chg` is high for exactly one cycle each time `gain_q` takes a different value. Writing the value already active produces no pulse.
- R9: A `vsync` falling edge with no staged gain pending leaves `gain_q` unchanged and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock from host, asynchronous to clk |
| sdata | input | 1 | Serial data, captured on sclk rising edge |
| vsync | input | 1 | Vertical sync; its falling edge applies a staged gain |
| ctrl_q | output | 16 | Control register contents |
| gain_q | output | 10 | Active amplifier gain |
| gain_on_vsync | output | 1 | Last written gain timing-select bit |
| gain_chg | output | 1 | One-cycle pulse when the active gain changes |

## Verification
A raw select rising edge reaches the second synchronizer flop and is seen as an edge after two clock edges, and the register updates on the third. The same three-edge latency applies from a raw `vsync` fall to a new `gain_q` and its `gain_chg` pulse. The bench therefore waits six clock cycles after each select release or vsync fall and samples on the falling clock edge, well clear of both the latency and the active edge. The gain pulses are counted by a monitor that runs on every clock. Each scenario compares the number of pulses counted before and after its stimulus, so a missing pulse, an extra pulse or a pulse wider than one cycle shows up as a wrong difference.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 16;
    localparam int GAIN_W       = 10;
    localparam int GAIN_SEL_BIT = 15;
    localparam logic [ADDR_W-1:0] CTRL_ADDR    = 8'hA2;
    localparam logic [ADDR_W-1:0] GAIN_ADDR    = 8'hA4;
    localparam logic [DATA_W-1:0] CTRL_DEFAULT = 16'h0009;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } frame_state_t;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
    parameter int              W       = 4,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            lvl_o  <= RST_VAL;
            prev_o <= RST_VAL;
        end else begin
            meta_q <= raw_i;
            lvl_o  <= meta_q;
            prev_o <= lvl_o;
        end
    end
endmodule

// File: rtl/ser_frame_fsm.sv
module ser_frame_fsm
    import ser_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_fall_i,
    input  logic          cs_rise_i,
    input  logic          sclk_rise_i,
    input  logic          sd_i,
    output logic          commit_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    localparam int FB  = AW + DW;
    localparam int CW  = $clog2(FB + 1);
    localparam logic [CW-1:0] LAST = CW'(FB - 1);
    localparam logic [CW-1:0] FULLCNT = CW'(FB);

    frame_state_t    state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [FB-1:0]   shreg_q;

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cs_fall_i) begin
                cnt_q <= '0;
            end else if (state_q == ST_SHIFT && !cs_rise_i && sclk_rise_i) begin
                cnt_q   <= cnt_q + 1'b1;
                shreg_q <= {shreg_q[FB-2:0], sd_i};
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall_i) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (cs_rise_i)                             state_d = ST_IDLE;
                else if (sclk_rise_i && cnt_q == LAST)     state_d = ST_FULL;
            end
            ST_FULL: begin
                if (cs_rise_i)        state_d = ST_IDLE;
                else if (sclk_rise_i) state_d = ST_OVER;
            end
            ST_OVER:  if (cs_rise_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit_o = (state_q == ST_FULL) && cs_rise_i;
        addr_o   = shreg_q[FB-1:DW];
        data_o   = shreg_q[DW-1:0];
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULLCNT) else $error("count overflow"); // R4
    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> cnt_q == FULLCNT) else $error("commit without 24 bits"); // R2
    AST_SHORT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_rise_i) |=> state_q == ST_IDLE) else $error("short frame kept"); // R3
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
    import ser_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          vs_fall_i,
    output logic [DW-1:0] ctrl_o,
    output logic [GW-1:0] gain_o,
    output logic          gain_sel_o,
    output logic          gain_chg_o
);
    logic [GW-1:0] stage_q;
    logic          pend_q;
    logic [GW-1:0] gain_d;
    logic          gain_unused_bits;

    assign gain_unused_bits = ^data_i[GAIN_SEL_BIT-1:GW];

    logic wr_ctrl, wr_gain;
    assign wr_ctrl = commit_i && addr_i == CTRL_ADDR;
    assign wr_gain = commit_i && addr_i == GAIN_ADDR;

    always_comb begin
        gain_d = gain_o;
        if (wr_gain && !data_i[GAIN_SEL_BIT]) gain_d = data_i[GW-1:0];
        else if (!wr_gain && vs_fall_i && pend_q) gain_d = stage_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_o     <= CTRL_DEFAULT;
            gain_o     <= '0;
            stage_q    <= '0;
            pend_q     <= 1'b0;
            gain_sel_o <= 1'b0;
            gain_chg_o <= 1'b0;
        end else begin
            gain_o     <= gain_d;
            gain_chg_o <= gain_d != gain_o;
            if (wr_ctrl) ctrl_o <= data_i;
            if (wr_gain) begin
                stage_q    <= data_i[GW-1:0];
                gain_sel_o <= data_i[GAIN_SEL_BIT];
                pend_q     <= data_i[GAIN_SEL_BIT];
            end else if (vs_fall_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(ctrl_o)) else $error("ctrl moved without commit"); // R3
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !vs_fall_i) |=> $stable(gain_o)) else $error("gain moved"); // R9
    AST_CHG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gain_chg_o) |-> gain_o != $past(gain_o)) else $error("pulse without change"); // R8
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_fall_i && !commit_i) |=> !pend_q) else $error("pending not cleared"); // R7
endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port
    import ser_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int GW = GAIN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk,
    input  logic          sdata,
    input  logic          vsync,
    output logic [DW-1:0] ctrl_q,
    output logic [GW-1:0] gain_q,
    output logic          gain_on_vsync,
    output logic          gain_chg
);
    localparam int NSIG = 4;

    logic [NSIG-1:0] lvl, prev;
    logic cs_fall, cs_rise, sclk_rise, vs_fall, commit;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;

    ser_sync #(.W(NSIG), .RST_VAL(4'b1001)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .raw_i({vsync, sdata, sclk, cs_n}),
        .lvl_o(lvl), .prev_o(prev)
    );

    assign cs_rise   =  lvl[0] & ~prev[0];
    assign cs_fall   = ~lvl[0] &  prev[0];
    assign sclk_rise =  lvl[1] & ~prev[1];
    assign vs_fall   = ~lvl[3] &  prev[3];

    ser_frame_fsm #(.AW(AW), .DW(DW)) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
        .sclk_rise_i(sclk_rise), .sd_i(lvl[2]),
        .commit_o(commit), .addr_o(addr), .data_o(data)
    );

    ser_reg_bank #(.AW(AW), .DW(DW), .GW(GW)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .addr_i(addr), .data_i(data),
        .vs_fall_i(vs_fall),
        .ctrl_o(ctrl_q), .gain_o(gain_q),
        .gain_sel_o(gain_on_vsync), .gain_chg_o(gain_chg)
    );
endmodule

// File: tb/ser_cfg_port_tb_top.sv
module ser_cfg_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0, vsync = 1'b1;
    logic [15:0] ctrl_q;
    logic [9:0]  gain_q;
    logic        gain_on_vsync, gain_chg;

    int n_chk = 0, n_fail = 0, chg_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata),
        .vsync(vsync), .ctrl_q(ctrl_q), .gain_q(gain_q),
        .gain_on_vsync(gain_on_vsync), .gain_chg(gain_chg)
    );

    always @(posedge clk) if (rst_n && gain_chg) chg_seen++;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [15:0] d, input int nbits);
        logic [23:0] w;
        w = {a, d};
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdata = (i < 24) ? w[23-i] : 1'b0;
            repeat (4) @(negedge clk); sclk = 1'b1;
            repeat (4) @(negedge clk); sclk = 1'b0;
        end
        repeat (4) @(negedge clk); cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic vs_pulse();
        @(negedge clk); vsync = 1'b0;
        repeat (6) @(negedge clk); vsync = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 ctrl", ctrl_q, 16'h0009);
        check("R1 gain", gain_q, 0);
        check("R1 sel", gain_on_vsync, 0);
        check("R1 pulses", chg_seen, 0);
    endtask

    task automatic t_ctrl_write();
        send(8'hA2, 16'h5A3C, 24);
        check("R2 ctrl 5A3C", ctrl_q, 16'h5A3C);
        send(8'hA2, 16'h8001, 24);
        check("R2 ctrl 8001", ctrl_q, 16'h8001);
    endtask

    task automatic t_short();
        send(8'hA2, 16'h1111, 23);
        check("R3 23 bits", ctrl_q, 16'h8001);
        send(8'hA2, 16'h2222, 8);
        check("R3 8 bits", ctrl_q, 16'h8001);
    endtask

    task automatic t_over();
        send(8'hA2, 16'h3333, 25);
        check("R4 25 bits", ctrl_q, 16'h8001);
    endtask

    task automatic t_bad_addr();
        send(8'h33, 16'h0155, 24);
        check("R5 ctrl", ctrl_q, 16'h8001);
        check("R5 gain", gain_q, 0);
    endtask

    task automatic t_gain_now();
        int c0;
        c0 = chg_seen;
        send(8'hA4, 16'h0155, 24);
        check("R6 gain", gain_q, 10'h155);
        check("R6 sel", gain_on_vsync, 0);
        check("R8 one pulse", chg_seen - c0, 1);
        c0 = chg_seen;
        send(8'hA4, 16'h0155, 24);
        check("R8 same value no pulse", chg_seen - c0, 0);
    endtask

    task automatic t_gain_vsync();
        int c0;
        c0 = chg_seen;
        send(8'hA4, 16'h82AA, 24);
        check("R7 held", gain_q, 10'h155);
        check("R7 sel", gain_on_vsync, 1);
        check("R7 no early pulse", chg_seen - c0, 0);
        vs_pulse();
        check("R7 applied", gain_q, 10'h2AA);
        check("R8 pulse on vsync", chg_seen - c0, 1);
        c0 = chg_seen;
        vs_pulse();
        check("R9 gain kept", gain_q, 10'h2AA);
        check("R9 no pulse", chg_seen - c0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_ctrl_write();
        t_short();
        t_over();
        t_bad_addr();
        t_gain_now();
        t_gain_vsync();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule